// File: doc/BRIEF.md
# Byte Execute Unit with Shift and Rotate

This block is the execute datapath of a small 8-bit RISC controller. Each cycle it takes an 18-bit instruction word and the two register operands that the register file reads for it: the destination/first operand and an optional second register. It then produces the result byte and a write enable for the destination register. Add and subtract, each with or without carry, AND, OR, a non-writing compare and a non-writing test are supported. Ten single-register shift and rotate forms are also supported.

The result and the write enable are combinational. The CARRY and ZERO flags are held in registers inside the block. The flags advance only on a clock edge where the execute strobe is high and the instruction is recognised. The carry-using instructions read the flag value held before that edge, so a chain of ADDCY or SUBCY instructions builds a wide add or subtract, one byte per strobe. Register storage, fetch, program flow and memory or port accesses live outside this block.

Top module: `exec_alu8`

## Requirements
- R1: Instruction fields: opcode in bits 17:12, destination index in 11:8, second register index in 7:4, immediate byte in 7:0. When bit 12 is 0 the second operand is the immediate byte. When bit 12 is 1 it is `ry_val`.
- R2: Opcode bits 17:13 = 01100 (ADD) writes sX+op2. Opcode 01101 (ADDCY) writes sX+op2+CARRY. In both, CARRY takes the carry out of bit 7.
- R3: Opcode 01110 (SUB) writes sX-op2. Opcode 01111 (SUBCY) writes sX-op2-CARRY. In both, CARRY is set on borrow.
- R4: Opcode 00101 (AND) and opcode 00110 (OR) write the bitwise result and clear CARRY.
- R5: Opcode 01010 (COMPARE) never writes. It sets CARRY when op2 is greater than sX, and sets ZERO when op2 equals sX.
- R6: Opcode 01001 (TEST) never writes. ZERO is set when sX AND op2 is zero. CARRY is the odd parity of sX AND op2.
- R7: Left moves use opcode 100000 with bits 3:0 set to one of these codes. 0000 fills bit 0 from CARRY. 0010 rotates bit 7 into bit 0. 0100 copies bit 0 into itself. 0110 fills with 0. 0111 fills with 1.
- R8: Right moves use opcode 100000 with bits 3:0 set to one of these codes. 1000 fills bit 7 from CARRY. 1010 copies bit 7 into itself. 1100 rotates bit 0 into bit 7. 1110 fills with 0. 1111 fills with 1.
- R9: Every shift and rotate writes sX. CARRY takes the bit moved out (bit 7 on left moves, bit 0 on right moves). For every recognised instruction, ZERO is set when its result byte is zero.
- R10: Reset clears CARRY and ZERO. Flags change only on a clock edge with `exec_en` high. The carry-using instructions read the flags held before that edge.
- R11: An unlisted opcode, or a shift sub-code outside the ten listed, gives `rx_we` low and leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe; flags update on this edge |
| instr | input | 18 | Instruction word |
| rx_val | input | 8 | Value of destination register sX |
| ry_val | input | 8 | Value of second register sY |
| result | output | 8 | Result byte for sX |
| rx_we | output | 1 | Write enable for sX |
| carry_q | output | 1 | Registered CARRY flag |
| zero_q | output | 1 | Registered ZERO flag |

## Verification
On one strobed edge, a carry-consuming instruction reads the CARRY flag while that same edge overwrites the flag. The bench provokes this by chaining ADD then ADDCY across a 16-bit sum. It does the same with SLA and SRA, which take their fill bit from the old CARRY while loading the new CARRY with the bit moved out. The bench judges the case by sampling the combinational result before the edge and the flags after it, and compares both against hand-computed values. A fill that used the new carry, or a flag that failed to advance, therefore shows up as a mismatch.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int INSTR_W  = 18;
  localparam int OPC_HI   = 17;
  localparam int OPC_LO   = 12;
  localparam int SRC_BIT  = 12;
  localparam int SUB_W    = 4;
  localparam logic [5:0] MOVE_OPC = 6'b100000;

  localparam logic [4:0] BASE_ADD  = 5'b01100;
  localparam logic [4:0] BASE_ADDC = 5'b01101;
  localparam logic [4:0] BASE_SUB  = 5'b01110;
  localparam logic [4:0] BASE_SUBC = 5'b01111;
  localparam logic [4:0] BASE_AND  = 5'b00101;
  localparam logic [4:0] BASE_OR   = 5'b00110;
  localparam logic [4:0] BASE_CMP  = 5'b01010;
  localparam logic [4:0] BASE_TST  = 5'b01001;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_ADDC, OP_SUB, OP_SUBC,
    OP_AND, OP_OR, OP_CMP, OP_TST, OP_SHL, OP_SHR
  } alu_op_e;

  // fill source for shift/rotate, taken from sub-code bits 2:1
  typedef enum logic [1:0] {
    FILL_CARRY = 2'b00,
    FILL_MSB   = 2'b01,
    FILL_LSB   = 2'b10,
    FILL_CONST = 2'b11
  } fill_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_reg;
    fill_e   fill;
    logic    fill_bit;
    logic    wr;
    logic    flag_upd;
  } dec_t;
endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [SUB_W-1:0] sub;
  logic             sub_ok;

  assign sub    = instr[SUB_W-1:0];
  // constant fill uses bit 0 as the value; other fills need bit 0 clear
  assign sub_ok = (sub[2:1] == 2'b11) || !sub[0];

  always_comb begin
    dec          = '0;
    dec.op       = OP_NONE;
    dec.use_reg  = instr[SRC_BIT];
    dec.fill     = fill_e'(sub[2:1]);
    dec.fill_bit = sub[0];
    if (instr[OPC_HI:OPC_LO] == MOVE_OPC) begin
      if (sub_ok) dec.op = sub[3] ? OP_SHR : OP_SHL;
    end else begin
      unique case (instr[OPC_HI:OPC_LO+1])
        BASE_ADD:  dec.op = OP_ADD;
        BASE_ADDC: dec.op = OP_ADDC;
        BASE_SUB:  dec.op = OP_SUB;
        BASE_SUBC: dec.op = OP_SUBC;
        BASE_AND:  dec.op = OP_AND;
        BASE_OR:   dec.op = OP_OR;
        BASE_CMP:  dec.op = OP_CMP;
        BASE_TST:  dec.op = OP_TST;
        default:   dec.op = OP_NONE;
      endcase
    end
    dec.flag_upd = (dec.op != OP_NONE);
    dec.wr       = dec.flag_upd && (dec.op != OP_CMP) && (dec.op != OP_TST);
  end
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic              ci;
  logic [DATA_W:0]   sum;
  logic [DATA_W:0]   diff;
  logic [DATA_W-1:0] conj;

  assign ci   = ((op == OP_ADDC) || (op == OP_SUBC)) ? cin : 1'b0;
  assign sum  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
  assign diff = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, ci};
  assign conj = a & b;

  always_comb begin
    res  = '0;
    cout = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDC: begin res = sum[DATA_W-1:0];  cout = sum[DATA_W];  end
      OP_SUB, OP_SUBC,
      OP_CMP:          begin res = diff[DATA_W-1:0]; cout = diff[DATA_W]; end
      OP_AND:          begin res = conj;             cout = 1'b0;         end
      OP_OR:           begin res = a | b;            cout = 1'b0;         end
      OP_TST:          begin res = conj;             cout = ^conj;        end
      default:         begin res = '0;               cout = 1'b0;         end
    endcase
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              right,
  input  fill_e             fill,
  input  logic              fill_bit,
  input  logic              cin,
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic              fb;
  logic [DATA_W-1:0] lft;
  logic [DATA_W-1:0] rgt;

  always_comb begin
    unique case (fill)
      FILL_CARRY: fb = cin;
      FILL_MSB:   fb = a[DATA_W-1];
      FILL_LSB:   fb = a[0];
      default:    fb = fill_bit;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign lft[i] = fb;
      assign rgt[i] = a[i+1];
    end else if (i == DATA_W-1) begin : g_hi
      assign lft[i] = a[i-1];
      assign rgt[i] = fb;
    end else begin : g_mid
      assign lft[i] = a[i-1];
      assign rgt[i] = a[i+1];
    end
  end

  assign res  = right ? rgt : lft;
  assign cout = right ? a[0] : a[DATA_W-1];
endmodule

// File: rtl/exec_alu8.sv
module exec_alu8
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                exec_en,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [DATA_W-1:0]   rx_val,
  input  logic [DATA_W-1:0]   ry_val,
  output logic [DATA_W-1:0]   result,
  output logic                rx_we,
  output logic                carry_q,
  output logic                zero_q
);
  dec_t              dec;
  logic [DATA_W-1:0] op2;
  logic [DATA_W-1:0] ar_res;
  logic              ar_c;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  logic              is_move;
  logic              nxt_c;
  logic              nxt_z;

  alu8_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign op2 = dec.use_reg ? ry_val : instr[DATA_W-1:0];

  alu8_arith #(.DATA_W(DATA_W)) u_arith (
    .op   (dec.op),
    .a    (rx_val),
    .b    (op2),
    .cin  (carry_q),
    .res  (ar_res),
    .cout (ar_c)
  );

  alu8_shifter #(.DATA_W(DATA_W)) u_shift (
    .right    (dec.op == OP_SHR),
    .fill     (dec.fill),
    .fill_bit (dec.fill_bit),
    .cin      (carry_q),
    .a        (rx_val),
    .res      (sh_res),
    .cout     (sh_c)
  );

  assign is_move = (dec.op == OP_SHL) || (dec.op == OP_SHR);
  assign result  = is_move ? sh_res : ar_res;
  assign rx_we   = dec.wr;
  assign nxt_c   = is_move ? sh_c : ar_c;
  assign nxt_z   = (result == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (exec_en && dec.flag_upd) begin
      carry_q <= nxt_c;
      zero_q  <= nxt_z;
    end
  end
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker (
  input logic        clk,
  input logic        rst,
  input logic        exec_en,
  input logic [17:0] instr,
  input logic [7:0]  rx_val,
  input logic [7:0]  result,
  input logic        rx_we,
  input logic        carry_q,
  input logic        zero_q
);
  logic is_move;
  assign is_move = (instr[17:12] == 6'b100000);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable({carry_q, zero_q}));

  // R5
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[17:13] == 5'b01010) |-> !rx_we);

  // R6
  tst_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[17:13] == 5'b01001) |-> !rx_we);

  // R4
  logic_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && ((instr[17:13] == 5'b00101) || (instr[17:13] == 5'b00110))) |=> !carry_q);

  // R9
  shr_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && is_move && instr[3] && rx_we) |=> (carry_q == $past(rx_val[0])));

  // R9
  shl_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && is_move && !instr[3] && rx_we) |=> (carry_q == $past(rx_val[7])));

  // R9
  zero_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && rx_we) |=> (zero_q == ($past(result) == 8'h00)));

  // R11
  bad_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && is_move && !rx_we) |=> $stable({carry_q, zero_q}));
endmodule

bind exec_alu8 alu8_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .exec_en (exec_en),
  .instr   (instr),
  .rx_val  (rx_val),
  .result  (result),
  .rx_we   (rx_we),
  .carry_q (carry_q),
  .zero_q  (zero_q)
);

// File: tb/sim_exec_alu8.sv
module sim_exec_alu8;
  localparam int CLK_P = 10;
  localparam int NV    = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_en = 1'b0;
  logic [17:0] instr = '0;
  logic [7:0]  rx_val = '0;
  logic [7:0]  ry_val = '0;
  logic [7:0]  result;
  logic        rx_we;
  logic        carry_q;
  logic        zero_q;

  int total = 0;
  int fails = 0;
  logic [7:0] got_res;
  logic       got_we;

  always #(CLK_P/2) clk = ~clk;

  exec_alu8 u0 (
    .clk(clk), .rst(rst), .exec_en(exec_en), .instr(instr),
    .rx_val(rx_val), .ry_val(ry_val), .result(result), .rx_we(rx_we),
    .carry_q(carry_q), .zero_q(zero_q)
  );

  // {instr, rx, ry, carry_in, exp_result, exp_we, exp_carry, exp_zero}
  localparam logic [45:0] VEC [NV] = '{
    {6'b011000,4'd3,8'h47,        8'h3A,8'hFF,1'b0, 8'h81,1'b1,1'b0,1'b0}, // R1 R2 imm
    {6'b011001,4'd3,4'd5,4'd0,    8'hF0,8'h10,1'b0, 8'h00,1'b1,1'b1,1'b1}, // R1 R2 reg
    {6'b011010,4'd3,8'h00,        8'h7F,8'h00,1'b1, 8'h80,1'b1,1'b0,1'b0}, // R2
    {6'b011011,4'd3,4'd5,4'd0,    8'hFF,8'h00,1'b1, 8'h00,1'b1,1'b1,1'b1}, // R2
    {6'b011100,4'd3,8'h20,        8'h10,8'h00,1'b0, 8'hF0,1'b1,1'b1,1'b0}, // R3
    {6'b011111,4'd3,4'd5,4'd0,    8'h05,8'h04,1'b1, 8'h00,1'b1,1'b0,1'b1}, // R3
    {6'b011110,4'd3,8'h00,        8'h00,8'h00,1'b1, 8'hFF,1'b1,1'b1,1'b0}, // R3
    {6'b001010,4'd3,8'h0F,        8'hF0,8'h00,1'b1, 8'h00,1'b1,1'b0,1'b1}, // R4
    {6'b001101,4'd3,4'd5,4'd0,    8'h12,8'h40,1'b1, 8'h52,1'b1,1'b0,1'b0}, // R4
    {6'b010100,4'd3,8'h31,        8'h30,8'h00,1'b0, 8'h00,1'b0,1'b1,1'b0}, // R5
    {6'b010101,4'd3,4'd5,4'd0,    8'h55,8'h55,1'b1, 8'h00,1'b0,1'b0,1'b1}, // R5
    {6'b010010,4'd3,8'h0F,        8'hB6,8'h00,1'b1, 8'h00,1'b0,1'b0,1'b0}, // R6
    {6'b010011,4'd3,4'd5,4'd0,    8'h07,8'hFF,1'b0, 8'h00,1'b0,1'b1,1'b0}, // R6
    {6'b010010,4'd3,8'h0F,        8'hF0,8'h00,1'b1, 8'h00,1'b0,1'b0,1'b1}, // R6
    {6'b100000,4'd2,8'h00,        8'h81,8'h00,1'b1, 8'h03,1'b1,1'b1,1'b0}, // R7 SLA
    {6'b100000,4'd2,8'h02,        8'h81,8'h00,1'b0, 8'h03,1'b1,1'b1,1'b0}, // R7 RL
    {6'b100000,4'd2,8'h04,        8'h41,8'h00,1'b1, 8'h83,1'b1,1'b0,1'b0}, // R7 SLX
    {6'b100000,4'd2,8'h06,        8'h80,8'h00,1'b0, 8'h00,1'b1,1'b1,1'b1}, // R7 SL0
    {6'b100000,4'd2,8'h07,        8'h00,8'h00,1'b0, 8'h01,1'b1,1'b0,1'b0}, // R7 SL1
    {6'b100000,4'd2,8'h08,        8'h02,8'h00,1'b1, 8'h81,1'b1,1'b0,1'b0}, // R8 SRA
    {6'b100000,4'd2,8'h0A,        8'h81,8'h00,1'b0, 8'hC0,1'b1,1'b1,1'b0}, // R8 SRX
    {6'b100000,4'd2,8'h0C,        8'h01,8'h00,1'b0, 8'h80,1'b1,1'b1,1'b0}, // R8 RR
    {6'b100000,4'd2,8'h0E,        8'h01,8'h00,1'b1, 8'h00,1'b1,1'b1,1'b1}, // R8 SR0
    {6'b100000,4'd2,8'h0F,        8'h00,8'h00,1'b1, 8'h80,1'b1,1'b0,1'b0}  // R8 SR1
  };

  function automatic string tag_of(input logic [17:0] i);
    case (i[17:13])
      5'b01100, 5'b01101: return "R2";
      5'b01110, 5'b01111: return "R3";
      5'b00101, 5'b00110: return "R4";
      5'b01010:           return "R5";
      5'b01001:           return "R6";
      default:            return i[3] ? "R8/R9" : "R7/R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic apply(input logic [17:0] i, input logic [7:0] x,
                       input logic [7:0] y, input logic en);
    @(negedge clk);
    instr = i; rx_val = x; ry_val = y; exec_en = en;
    #(CLK_P/4);
    got_res = result;
    got_we  = rx_we;
    @(posedge clk);
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic set_carry(input logic c);
    if (c) apply({6'b011100, 4'd0, 8'h01}, 8'h00, 8'h00, 1'b1); // 0-1: borrow, Z=0
    else   apply({6'b001010, 4'd0, 8'h00}, 8'h00, 8'h00, 1'b1); // AND 0: C=0, Z=1
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "reset carry", carry_q, 0);
    chk("R10", "reset zero", zero_q, 0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      set_carry(VEC[k][11]);
      apply(VEC[k][45:28], VEC[k][27:20], VEC[k][19:12], 1'b1);
      if (VEC[k][2]) chk(tag_of(VEC[k][45:28]), $sformatf("result v%0d", k), got_res, VEC[k][10:3]);
      chk(tag_of(VEC[k][45:28]), $sformatf("we v%0d", k), got_we, VEC[k][2]);
      chk(tag_of(VEC[k][45:28]), $sformatf("carry v%0d", k), carry_q, VEC[k][1]);
      chk(tag_of(VEC[k][45:28]), $sformatf("zero v%0d", k), zero_q, VEC[k][0]);
    end

    // R1: immediate form ignores ry_val
    set_carry(1'b0);
    apply({6'b011000, 4'd1, 8'h01}, 8'h01, 8'h80, 1'b1);
    chk("R1", "imm ignores ry", got_res, 8'h02);

    // R10: carry chain, 0x01FF + 0x0001 = 0x0200
    apply({6'b011000, 4'd1, 8'h01}, 8'hFF, 8'h00, 1'b1);
    chk("R10", "low byte", got_res, 8'h00);
    chk("R10", "low carry", carry_q, 1);
    apply({6'b011010, 4'd2, 8'h00}, 8'h01, 8'h00, 1'b1);
    chk("R10", "high byte uses old carry", got_res, 8'h02);
    chk("R10", "high carry", carry_q, 0);

    // R10: no strobe, flags hold
    set_carry(1'b1);
    apply({6'b011000, 4'd1, 8'h00}, 8'h00, 8'h00, 1'b0);
    chk("R10", "hold carry", carry_q, 1);
    chk("R10", "hold zero", zero_q, 0);

    // R11: bad shift sub-code
    set_carry(1'b1);
    apply({6'b100000, 4'd1, 8'h01}, 8'h00, 8'h00, 1'b1);
    chk("R11", "bad sub we", got_we, 0);
    chk("R11", "bad sub carry", carry_q, 1);
    chk("R11", "bad sub zero", zero_q, 0);

    // R11: unlisted opcode
    set_carry(1'b0);
    apply({6'b111111, 4'd1, 8'hFF}, 8'hFF, 8'hFF, 1'b1);
    chk("R11", "bad op we", got_we, 0);
    chk("R11", "bad op carry", carry_q, 0);
    chk("R11", "bad op zero", zero_q, 1);

    // R10: reset mid-run clears flags
    set_carry(1'b1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10", "mid reset carry", carry_q, 0);
    chk("R10", "mid reset zero", zero_q, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule